// File: doc/BRIEF.md
# Legacy Graphics I/O Router

This block steers each host I/O cycle to one of two downstream targets: a secondary graphics port or a hub port. A request is a 16-bit I/O address with a valid strobe. Three static configuration bits shape the decision: a VGA forwarding enable, an I/O access enable for the graphics side, and a flag that says a monochrome display adapter sits on the hub side.

The legacy VGA ports at 3B0h–3BBh and 3C0h–3DFh go to the graphics port only when both enables are set. When the monochrome flag is set, six monochrome ports are pulled back to the hub. This happens even while VGA forwarding stays on. Any address that no rule claims goes to the hub.

The route decision is registered. A one-hot route and a valid pulse appear one clock after the request.

Top module: `gfx_io_router`

## Requirements
- R1: `route_valid_o` is high exactly in the cycle after a cycle in which `req_valid_i` was high. While it is low, `route_o` is 2'b00.
- R2: While `route_valid_o` is high, `route_o` has exactly one bit set. Bit 0 selects the graphics port and bit 1 selects the hub port.
- R3: With both enables set and the monochrome flag clear, every address in 3B0h–3BBh or 3C0h–3DFh is routed to the graphics port (2'b01).
- R4: With `vga_en_i` clear, addresses in the legacy VGA ranges are routed to the hub (2'b10).
- R5: With `io_en_i` clear, no I/O cycle is routed to the graphics port, whatever the other bits are.
- R6: With `mono_en_i` set, addresses 3B4h, 3B5h, 3B8h, 3B9h, 3BAh and 3BFh are routed to the hub, even when both enables are set.
- R7: With `mono_en_i` set and both enables set, the other legacy VGA addresses (for example 3B0h, 3B6h, 3BBh and 3C0h) still go to the graphics port.
- R8: An address outside both VGA ranges goes to the hub. The whole 16-bit address is compared, so 13C0h goes to the hub.
- R9: While `rst_ni` is low, `route_valid_o` and `route_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | An I/O cycle is presented this cycle |
| io_addr_i | input | 16 | I/O port address |
| vga_en_i | input | 1 | Forward legacy VGA ranges to the graphics port |
| io_en_i | input | 1 | Allow any I/O routing to the graphics port |
| mono_en_i | input | 1 | A monochrome adapter is present on the hub side |
| route_valid_o | output | 1 | Route result valid; one cycle after the request |
| route_o | output | 2 | One-hot target: bit 0 graphics, bit 1 hub |

## Verification
A bad valid register shows up as a missing result, a duplicated result or a shifted result. The scoreboard flags it in the very cycle after the request, either as an unexpected valid or as an empty slot where a result was due.

A wrong comparator bound or a wrong monochrome port entry sends one address to the wrong port. It is only visible when that exact address is sent, so the stimulus covers the edges of both ranges and every port in the monochrome set, with the flag set and with it clear.

Back-to-back requests check that each result belongs to its own cycle, with no state carried over from the previous request.

// File: rtl/gfx_io_pkg.sv
package gfx_io_pkg;
  localparam int unsigned PORT_W = 16;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_GFX  = 2'b01,
    ROUTE_HUB  = 2'b10
  } route_e;

  localparam int unsigned N_VGA_RANGES = 2;
  localparam logic [PORT_W-1:0] VGA_LO [N_VGA_RANGES] = '{16'h03B0, 16'h03C0};
  localparam logic [PORT_W-1:0] VGA_HI [N_VGA_RANGES] = '{16'h03BB, 16'h03DF};

  localparam int unsigned N_MONO_PORTS = 6;
  localparam logic [PORT_W-1:0] MONO_PORTS [N_MONO_PORTS] =
    '{16'h03B4, 16'h03B5, 16'h03B8, 16'h03B9, 16'h03BA, 16'h03BF};
endpackage

// File: rtl/gfx_io_vga_dec.sv
module gfx_io_vga_dec
  import gfx_io_pkg::*;
#(
  parameter int unsigned ADDR_W = PORT_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [N_VGA_RANGES-1:0] in_range;

  for (genvar g = 0; g < N_VGA_RANGES; g++) begin : g_range
    assign in_range[g] = (addr_i >= ADDR_W'(VGA_LO[g])) && (addr_i <= ADDR_W'(VGA_HI[g]));
  end

  assign hit_o = |in_range;
endmodule

// File: rtl/gfx_io_mono_dec.sv
module gfx_io_mono_dec
  import gfx_io_pkg::*;
#(
  parameter int unsigned ADDR_W = PORT_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic              hit_o
);
  logic [N_MONO_PORTS-1:0] match;

  for (genvar g = 0; g < N_MONO_PORTS; g++) begin : g_port
    assign match[g] = (addr_i == ADDR_W'(MONO_PORTS[g]));
  end

  assign hit_o = en_i & (|match);
endmodule

// File: rtl/gfx_io_route_reg.sv
module gfx_io_route_reg
  import gfx_io_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  input  route_e route_i,
  output logic   valid_o,
  output route_e route_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      route_o <= ROUTE_NONE;
    end else begin
      valid_o <= valid_i;
      route_o <= valid_i ? route_i : ROUTE_NONE;
    end
  end
endmodule

// File: rtl/gfx_io_router.sv
module gfx_io_router
  import gfx_io_pkg::*;
#(
  parameter int unsigned ADDR_W = PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              vga_en_i,
  input  logic              io_en_i,
  input  logic              mono_en_i,
  output logic              route_valid_o,
  output logic [1:0]        route_o
);
  logic   vga_hit, mono_hit, to_gfx;
  route_e route_d, route_q;

  gfx_io_vga_dec #(.ADDR_W(ADDR_W)) u_vga (
    .addr_i (io_addr_i),
    .hit_o  (vga_hit)
  );

  gfx_io_mono_dec #(.ADDR_W(ADDR_W)) u_mono (
    .addr_i (io_addr_i),
    .en_i   (mono_en_i),
    .hit_o  (mono_hit)
  );

  // monochrome claim overrides VGA forwarding
  assign to_gfx  = io_en_i & vga_en_i & vga_hit & ~mono_hit;
  assign route_d = to_gfx ? ROUTE_GFX : ROUTE_HUB;

  gfx_io_route_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .route_i (route_d),
    .valid_o (route_valid_o),
    .route_o (route_q)
  );

  assign route_o = route_q;
endmodule

// File: rtl/gfx_io_router_chk.sv
module gfx_io_router_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              vga_en_i,
  input logic              io_en_i,
  input logic              mono_en_i,
  input logic              route_valid_o,
  input logic [1:0]        route_o
);
  logic armed;
  logic mono_port;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  always_comb begin
    case (io_addr_i)
      ADDR_W'(16'h03B4), ADDR_W'(16'h03B5), ADDR_W'(16'h03B8),
      ADDR_W'(16'h03B9), ADDR_W'(16'h03BA), ADDR_W'(16'h03BF): mono_port = 1'b1;
      default: mono_port = 1'b0;
    endcase
  end

  // R1
  p_valid_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (route_valid_o == $past(req_valid_i)));
  // R1
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_valid_o |-> (route_o == 2'b00));
  // R2
  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_valid_o |-> ($countones(route_o) == 1));
  // R4
  p_vga_off_hub_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(req_valid_i && !vga_en_i)) |-> (route_o == 2'b10));
  // R5
  p_io_off_hub_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(req_valid_i && !io_en_i)) |-> (route_o == 2'b10));
  // R6
  p_mono_hub_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(req_valid_i && mono_en_i && mono_port)) |-> (route_o == 2'b10));
  // R9
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r9: assert (!route_valid_o && route_o == 2'b00);
    end
  end
endmodule

bind gfx_io_router gfx_io_router_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_gfx_io_router.sv
`timescale 1ns/1ps
module sim_gfx_io_router;
  localparam time TCK = 5ns;

  typedef struct {
    logic [1:0] route;
    string      tag;
    logic [15:0] addr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] io_addr = '0;
  logic        vga_en = 1'b0, io_en = 1'b0, mono_en = 1'b0;
  logic        route_valid;
  logic [1:0]  route;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  always #(TCK/2) clk = ~clk;

  gfx_io_router u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .req_valid_i   (req_valid),
    .io_addr_i     (io_addr),
    .vga_en_i      (vga_en),
    .io_en_i       (io_en),
    .mono_en_i     (mono_en),
    .route_valid_o (route_valid),
    .route_o       (route)
  );

  localparam logic [1:0] GFX = 2'b01;
  localparam logic [1:0] HUB = 2'b10;

  task automatic send(input logic [15:0] a, input logic v, input logic i,
                      input logic m, input logic [1:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; io_addr = a; vga_en = v; io_en = i; mono_en = m;
    e.route = exp; e.tag = tag; e.addr = a;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      io_addr = 16'hDEAD;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          checks++;
          if (!route_valid || route !== e.route) begin
            errors++;
            $display("FAIL %s addr=%h: valid=%b route=%b expected valid=1 route=%b",
                     e.tag, e.addr, route_valid, route, e.route);
          end
        end else begin
          checks++;
          if (route_valid !== 1'b0 || route !== 2'b00) begin
            errors++;
            $display("FAIL R1 idle: valid=%b route=%b expected valid=0 route=00",
                     route_valid, route);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    #(TCK * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R9: reset state, with a request held during reset
    repeat (3) @(negedge clk);
    req_valid = 1'b1; io_addr = 16'h03C0; vga_en = 1; io_en = 1;
    @(posedge clk); #2;
    checks++;
    if (route_valid !== 1'b0 || route !== 2'b00) begin
      errors++;
      $display("FAIL R9: valid=%b route=%b expected valid=0 route=00", route_valid, route);
    end
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b1;
    idle(2);

    // R3: VGA ranges to graphics, both edges
    send(16'h03B0, 1, 1, 0, GFX, "R3");
    send(16'h03BB, 1, 1, 0, GFX, "R3");
    send(16'h03C0, 1, 1, 0, GFX, "R3");
    send(16'h03DF, 1, 1, 0, GFX, "R3");
    send(16'h03D4, 1, 1, 0, GFX, "R3");
    send(16'h03B4, 1, 1, 0, GFX, "R3");
    send(16'h03BA, 1, 1, 0, GFX, "R3");
    idle(2);

    // R8: unclaimed addresses to hub
    send(16'h03AF, 1, 1, 0, HUB, "R8");
    send(16'h03BC, 1, 1, 0, HUB, "R8");
    send(16'h03BF, 1, 1, 0, HUB, "R8");
    send(16'h03E0, 1, 1, 0, HUB, "R8");
    send(16'h0000, 1, 1, 0, HUB, "R8");
    send(16'hFFFF, 1, 1, 0, HUB, "R8");
    send(16'h13C0, 1, 1, 0, HUB, "R8");
    idle(1);

    // R4: VGA forwarding off
    send(16'h03C0, 0, 1, 0, HUB, "R4");
    send(16'h03B4, 0, 1, 0, HUB, "R4");
    send(16'h03DF, 0, 1, 1, HUB, "R4");
    idle(1);

    // R5: I/O access off
    send(16'h03D4, 1, 0, 0, HUB, "R5");
    send(16'h03B0, 1, 0, 0, HUB, "R5");
    send(16'h03B6, 1, 0, 1, HUB, "R5");
    idle(3);

    // R6: monochrome ports to hub
    send(16'h03B4, 1, 1, 1, HUB, "R6");
    send(16'h03B5, 1, 1, 1, HUB, "R6");
    send(16'h03B8, 1, 1, 1, HUB, "R6");
    send(16'h03B9, 1, 1, 1, HUB, "R6");
    send(16'h03BA, 1, 1, 1, HUB, "R6");
    send(16'h03BF, 1, 1, 1, HUB, "R6");

    // R7: rest of VGA range still to graphics with mono flag set
    send(16'h03B0, 1, 1, 1, GFX, "R7");
    send(16'h03B3, 1, 1, 1, GFX, "R7");
    send(16'h03B6, 1, 1, 1, GFX, "R7");
    send(16'h03B7, 1, 1, 1, GFX, "R7");
    send(16'h03BB, 1, 1, 1, GFX, "R7");
    send(16'h03C0, 1, 1, 1, GFX, "R7");

    // R2/R1: alternating targets back to back
    for (int k = 0; k < 8; k++) begin
      if (k % 2 == 0) send(16'h03C5, 1, 1, 0, GFX, "R2");
      else            send(16'h03B5, 1, 1, 1, HUB, "R2");
    end
    idle(4);

    wait (q.size() == 0);
    idle(2);
    finish_run();
  end
endmodule